// File: doc/BRIEF.md
# Shadowed SRAM store/recall controller

This block is a byte-wide memory in which every location exists twice. There is a volatile working copy that the host reads and writes, and a nonvolatile shadow copy behind it. Three active-low strobes select standby, read or write: chip select, write strobe and output gate. The shadow copy is only touched by two bulk transfers. A save copies working to shadow. A restore copies shadow to working and runs by itself when the block comes out of reset, which models power-up.

A save starts in one of two ways. The host side can pull a shared open-drain request/busy line low, or a power-fail input can rise. The block itself holds that line low for the whole save, so other agents on the line see the block as busy. A save only copies when the working array has been written since the last save or restore; otherwise the copy is skipped. In both cases the block then refuses all access until the request line is high again and power-fail is low.

The array size and the save/restore lengths are parameters. The transfers walk one location per clock and are then stretched by a settle tail. Host access is refused throughout the transfer.

Top module: `nv_shadow_sram`

## Requirements
- R1: With `ce_n` high the data bus is not driven (`dq_oe` = 0), and a write strobe has no effect on the array.
- R2: With `ce_n` low, `we_n` high, the request line high and the block idle, the content of `addr` appears on `dq_o` with `dq_oe` = 1 in the same cycle when `oe_n` is low. `dq_oe` is 0 whenever `oe_n` is high.
- R3: With `ce_n` low, `we_n` low, the request line high and the block idle, `dq_i` is written to `addr` at the clock edge, and the bus is not driven.
- R4: A low level on `line_i` while idle starts a save whatever `ce_n` and `we_n` are. While the save runs, `line_pull_o` is 1 for exactly 2^ADDR_W + STORE_EXTRA cycles.
- R5: A save copies the working array into the shadow array only if at least one write was accepted since the last save or restore. Otherwise `line_pull_o` stays 0 and the shadow is unchanged. A completed save clears that condition.
- R6: After a save completes or is skipped, reads and writes are refused until `line_i` is high and `pfail_i` is low. They are accepted again from the next cycle.
- R7: A high `pfail_i` while idle starts the same conditional save, with the same busy length as R4.
- R8: After reset is released, a restore runs for 2^ADDR_W + RECALL_EXTRA cycles with access refused. Afterwards every working location equals its shadow location, and the written-since condition is clear.
- R9: Reads and writes are refused while `line_i` is low, while `pfail_i` is high, and during a save or restore. A refused write leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release models power-up and starts a restore |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W | Location address |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |
| line_i | input | 1 | Sensed level of the shared request/busy line |
| line_pull_o | output | 1 | Pulls the request/busy line low while a save runs |
| pfail_i | input | 1 | Power-fail warning, active high |

## Verification
The bench builds the block with ADDR_W = 4, STORE_EXTRA = 3, RECALL_EXTRA = 2 and no input synchronizer stages. With 16 locations and 19/18-cycle transfers, whole-array saves, restores and power cycles take only a few dozen cycles each. This puts the exact busy and restore lengths, the skipped save on a clean array and the loss of unsaved writes across a reset within reach of a short run. Removing the synchronizers makes the request line take effect at the very next edge, so the bench can place a write in the same cycle as a save request and observe that it is refused.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [1:0] {
      NVS_RECALL = 2'd0,
      NVS_ACTIVE = 2'd1,
      NVS_STORE  = 2'd2,
      NVS_HOLD   = 2'd3
   } nvs_state_e;

endpackage

// File: rtl/nvs_in_sync.sv
module nvs_in_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= RST_VAL;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RST_VAL}};
            else        sh_q <= {sh_q[STAGES-2:0], d};
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              save_en,
   input  logic              restore_en,
   input  logic [ADDR_W-1:0] copy_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] work_mem   [DEPTH];
   logic [DATA_W-1:0] shadow_mem [DEPTH];

   // working copy: restore has priority; host writes are gated off upstream anyway
   always_ff @(posedge clk) begin
      if (restore_en)
         work_mem[copy_addr] <= shadow_mem[copy_addr];
      else if (wr_en)
         work_mem[wr_addr] <= wr_data;
   end

   // shadow copy: no reset, it survives power cycles
   always_ff @(posedge clk) begin
      if (save_en)
         shadow_mem[copy_addr] <= work_mem[copy_addr];
   end

   assign rd_data = work_mem[rd_addr];

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int STORE_EXTRA  = 4,
   parameter int RECALL_EXTRA = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_s,
   input  logic              pfail_s,
   input  logic              ce_n,
   input  logic              we_n,
   output nvs_state_e        state_o,
   output logic              access_ok,
   output logic              host_wr,
   output logic              save_en,
   output logic              restore_en,
   output logic [ADDR_W-1:0] copy_addr,
   output logic              dirty_o
);

   localparam int DEPTH      = 1 << ADDR_W;
   localparam int STORE_CYC  = DEPTH + STORE_EXTRA;
   localparam int RECALL_CYC = DEPTH + RECALL_EXTRA;
   localparam int CNT_MAX    = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   nvs_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              dirty_q;
   logic              in_copy;

   assign in_copy    = (cnt_q < CNT_W'(DEPTH));
   assign access_ok  = (state_q == NVS_ACTIVE) && line_s && !pfail_s;
   assign host_wr    = access_ok && !ce_n && !we_n;
   assign save_en    = (state_q == NVS_STORE)  && in_copy;
   assign restore_en = (state_q == NVS_RECALL) && in_copy;
   assign copy_addr  = cnt_q[ADDR_W-1:0];
   assign state_o    = state_q;
   assign dirty_o    = dirty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= NVS_RECALL;
         cnt_q   <= '0;
         dirty_q <= 1'b0;
      end else begin
         unique case (state_q)
            NVS_RECALL: begin
               if (cnt_q == CNT_W'(RECALL_CYC - 1)) begin
                  state_q <= NVS_ACTIVE;
                  cnt_q   <= '0;
                  dirty_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            NVS_ACTIVE: begin
               if (!line_s || pfail_s) begin
                  state_q <= dirty_q ? NVS_STORE : NVS_HOLD;
                  cnt_q   <= '0;
               end else if (host_wr) begin
                  dirty_q <= 1'b1;
               end
            end
            NVS_STORE: begin
               if (cnt_q == CNT_W'(STORE_CYC - 1)) begin
                  state_q <= NVS_HOLD;
                  cnt_q   <= '0;
                  dirty_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            NVS_HOLD: begin
               if (line_s && !pfail_s)
                  state_q <= NVS_ACTIVE;
            end
            default: state_q <= NVS_RECALL;
         endcase
      end
   end

endmodule

// File: rtl/nv_shadow_sram.sv
module nv_shadow_sram
   import nvs_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter int STORE_EXTRA  = 4,
   parameter int RECALL_EXTRA = 4,
   parameter int IN_SYNC      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   input  logic              line_i,
   output logic              line_pull_o,
   input  logic              pfail_i
);

   generate
      if (ADDR_W < 2 || ADDR_W > 15) begin : g_bad_addr_w
         $error("nv_shadow_sram: ADDR_W must lie in 2..15");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("nv_shadow_sram: DATA_W must be positive");
      end
      if (STORE_EXTRA < 0 || RECALL_EXTRA < 0) begin : g_bad_extra
         $error("nv_shadow_sram: settle tails must not be negative");
      end
      if (IN_SYNC < 0 || IN_SYNC > 4) begin : g_bad_sync
         $error("nv_shadow_sram: IN_SYNC must lie in 0..4");
      end
   endgenerate

   logic              line_s;
   logic              pfail_s;
   nvs_state_e        state;
   logic              access_ok;
   logic              host_wr;
   logic              save_en;
   logic              restore_en;
   logic [ADDR_W-1:0] copy_addr;
   logic [DATA_W-1:0] rd_data;
   logic              dirty_w;

   nvs_in_sync #(.STAGES(IN_SYNC), .RST_VAL(1'b1)) u_sync_line (
      .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s)
   );

   nvs_in_sync #(.STAGES(IN_SYNC), .RST_VAL(1'b0)) u_sync_pfail (
      .clk(clk), .rst_n(rst_n), .d(pfail_i), .q(pfail_s)
   );

   nvs_ctrl #(
      .ADDR_W(ADDR_W), .STORE_EXTRA(STORE_EXTRA), .RECALL_EXTRA(RECALL_EXTRA)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .line_s(line_s), .pfail_s(pfail_s),
      .ce_n(ce_n), .we_n(we_n), .state_o(state), .access_ok(access_ok),
      .host_wr(host_wr), .save_en(save_en), .restore_en(restore_en),
      .copy_addr(copy_addr), .dirty_o(dirty_w)
   );

   nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrays (
      .clk(clk), .wr_en(host_wr), .wr_addr(addr), .wr_data(dq_i),
      .save_en(save_en), .restore_en(restore_en), .copy_addr(copy_addr),
      .rd_addr(addr), .rd_data(rd_data)
   );

   assign dq_oe       = access_ok && !ce_n && we_n && !oe_n;
   assign dq_o        = dq_oe ? rd_data : '0;
   assign line_pull_o = (state == NVS_STORE);

endmodule

// File: rtl/nv_shadow_sram_chk.sv
module nv_shadow_sram_chk #(
   parameter int ADDR_W      = 10,
   parameter int STORE_EXTRA = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic we_n,
   input logic oe_n,
   input logic dq_oe,
   input logic line_pull_o,
   input logic line_s,
   input logic dirty
);

   localparam int STORE_CYC = (1 << ADDR_W) + STORE_EXTRA;

   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= 0;
      else if (line_pull_o) run_q <= run_q + 1;
      else                  run_q <= 0;
   end

   p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !dq_oe);

   p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   p_write_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !dq_oe);

   p_busy_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != 0 && !line_pull_o) |-> (run_q == STORE_CYC));

   p_save_needs_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_o) |-> $past(dirty));

   p_save_clears_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_pull_o) |-> !dirty);

   p_line_low_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_s |-> !dq_oe);

   p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_pull_o |-> !dq_oe);

endmodule

bind nv_shadow_sram nv_shadow_sram_chk #(
   .ADDR_W(ADDR_W), .STORE_EXTRA(STORE_EXTRA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
   .dq_oe(dq_oe), .line_pull_o(line_pull_o), .line_s(line_s), .dirty(dirty_w)
);

// File: tb/nv_shadow_sram_test.sv
module nv_shadow_sram_test;

   localparam int AW         = 4;
   localparam int DW         = 8;
   localparam int S_EXTRA    = 3;
   localparam int R_EXTRA    = 2;
   localparam int DEPTH      = 1 << AW;
   localparam int STORE_CYC  = DEPTH + S_EXTRA;
   localparam int RECALL_CYC = DEPTH + R_EXTRA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_i = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;
   logic          line_pull_o;
   logic          ext_pull = 1'b0;
   logic          pfail = 1'b0;
   logic          line;

   // open-drain line with pull-up: low if anyone pulls
   assign line = !(ext_pull || line_pull_o);

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] work_m [DEPTH];
   logic [DW-1:0] shad_m [DEPTH];

   always #2.5 clk = ~clk;

   nv_shadow_sram #(
      .ADDR_W(AW), .DATA_W(DW), .STORE_EXTRA(S_EXTRA),
      .RECALL_EXTRA(R_EXTRA), .IN_SYNC(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
      .line_i(line), .line_pull_o(line_pull_o), .pfail_i(pfail)
   );

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      return work_m[a];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; dq_i = d;
      cyc();
      idle();
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string req);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
      @(negedge clk);
      chk(req, int'(dq_oe), 1);
      chk(req, int'(dq_o), int'(exp_read(a)));
      cyc();
      idle();
   endtask

   // counts busy cycles over a window while trying to read; returns refused-read violations too
   task automatic busy_window(input int len, output int busy, output int drove);
      busy = 0; drove = 0;
      for (int i = 0; i < len; i++) begin
         ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(i);
         @(negedge clk);
         if (line_pull_o) busy++;
         if (dq_oe) drove++;
      end
      cyc();
      idle();
   endtask

   task automatic power_up(output int wait_cyc);
      rst_n = 1'b0;
      idle();
      repeat (3) cyc();
      rst_n = 1'b1;
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = '0;
      wait_cyc = 0;
      @(negedge clk);
      while (!dq_oe && wait_cyc < 200) begin
         @(negedge clk);
         wait_cyc++;
      end
      cyc();
      idle();
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      int n, busy, drove, op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      void'($urandom(32'd1234));

      // reset state (R8): no drive, no pull while held in reset
      #1;
      chk("R8 reset dq_oe", int'(dq_oe), 0);
      chk("R8 reset pull", int'(line_pull_o), 0);

      // first power-up: restore length
      power_up(n);
      chk("R8 restore length", n, RECALL_CYC);

      // fill the array and check it
      for (int i = 0; i < DEPTH; i++) begin
         d = DW'($urandom);
         do_write(AW'(i), d);
         work_m[i] = d;
      end
      for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R3 fill readback");

      // constrained random mix of read, write, standby, gated read
      for (int k = 0; k < 400; k++) begin
         op = int'($urandom % 4);
         a  = AW'($urandom);
         d  = DW'($urandom);
         case (op)
            0: begin do_write(a, d); work_m[a] = d; end
            1: do_read(a, "R2 random read");
            2: begin
               ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = a; dq_i = d;
               @(negedge clk);
               chk("R1 standby no drive", int'(dq_oe), 0);
               cyc();
               idle();
            end
            default: begin
               ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = a;
               @(negedge clk);
               chk("R2 output gate off", int'(dq_oe), 0);
               cyc();
               idle();
            end
         endcase
      end
      for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R1 standby writes ignored");

      // hardware save requested during a write strobe (R4, R9)
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 4'd5; dq_i = ~work_m[5];
      ext_pull = 1'b1;
      cyc();
      idle();
      for (int i = 0; i < DEPTH; i++) shad_m[i] = work_m[i];
      busy_window(60, busy, drove);
      chk("R4 busy length", busy, STORE_CYC - 1 + 1);
      chk("R9 no read during save/hold", drove, 0);
      // lockout while request held (R6): write attempt must be dropped
      do_write(4'd3, ~work_m[3]);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 4'd3;
      @(negedge clk);
      chk("R6 hold refuses read", int'(dq_oe), 0);
      cyc();
      idle();
      ext_pull = 1'b0;
      cyc();
      do_read(4'd3, "R6 hold write dropped");
      do_read(4'd5, "R9 write during request dropped");

      // immediate second request: array clean, save skipped (R5), still locks out (R6)
      ext_pull = 1'b1;
      cyc();
      busy_window(40, busy, drove);
      chk("R5 clean save skipped", busy, 0);
      chk("R6 skipped save locks out", drove, 0);
      ext_pull = 1'b0;
      cyc();
      do_read(4'd0, "R6 access back after release");

      // unsaved writes are lost across a power cycle (R8)
      for (int i = 0; i < DEPTH; i += 2) do_write(AW'(i), ~shad_m[i]);
      power_up(n);
      chk("R8 restore length again", n, RECALL_CYC);
      for (int i = 0; i < DEPTH; i++) work_m[i] = shad_m[i];
      for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R8 restored from shadow");

      // after restore the array is clean: request skips the save (R8, R5)
      ext_pull = 1'b1;
      cyc();
      busy_window(30, busy, drove);
      chk("R8 restore clears dirty", busy, 0);
      ext_pull = 1'b0;
      cyc();

      // power-fail triggered save with chip deselected (R7)
      for (int i = 0; i < DEPTH; i++) begin
         d = DW'($urandom);
         do_write(AW'(i), d);
         work_m[i] = d;
      end
      pfail = 1'b1;
      cyc();
      for (int i = 0; i < DEPTH; i++) shad_m[i] = work_m[i];
      busy_window(50, busy, drove);
      chk("R7 power-fail busy length", busy, STORE_CYC);
      chk("R7 no access during power-fail", drove, 0);
      do_write(4'd9, ~work_m[9]);
      pfail = 1'b0;
      cyc();
      do_read(4'd9, "R9 write under power-fail dropped");
      for (int i = 0; i < DEPTH; i += 2) do_write(AW'(i), 8'h00);
      power_up(n);
      for (int i = 0; i < DEPTH; i++) work_m[i] = shad_m[i];
      for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R7 power-fail save kept");

      summary();
   end

endmodule